// File: doc/BRIEF.md
# I2C DMA Byte Mover

This block sits beside the command sequencer of one I2C bus and moves payload bytes between system memory and the I2C byte stream, one byte per memory access. Software loads a start address and a byte count, then issues a command that enables either the transmit direction (bytes are read from memory and offered to the sequencer) or the receive direction (bytes handed over by the sequencer are written to memory). Every byte moved advances the address by one and reduces the remaining count by one, so after a transfer the two registers show where the engine stopped.

The memory side is a single-byte request channel with one request outstanding: the engine raises a request with an address, a write flag and write data, and holds it until the memory answers with a response strobe and an error flag. The sequencer side has a valid/ready byte handshake in each direction; on transmit the sequencer reports a NAK in the same cycle it takes a byte. When the build parameter that enables the engine is cleared, the registers and the direction bits of commands are dead.

Top module: `i2c_dma_mover`

## Requirements
- R1: A write to the address register (reg_sel = 0) stores the written value with its two lowest bits forced to zero; reading with reg_sel = 0 returns the stored address, and reset leaves it at zero.
- R2: A write to the length register (reg_sel = 1) keeps only bits 11:0 of the value; reading with reg_sel = 1 returns that count zero-extended, and reset leaves it at zero.
- R3: Writing a length whose low 12 bits are zero raises len_bad, and a later nonzero length write clears it; a transfer command issued while the length is zero issues no memory request and drops its enable bit.
- R4: In transmit mode each byte is read from memory at the current address and offered on tx_data; each successful memory read adds one to the address and subtracts one from the length, and when the length reaches zero the transmit enable (dma_en bit 0) clears.
- R5: When the transmit command carries cmd_start, the first byte offered is flagged on tx_first; every later byte of that transfer, and every byte of a transfer without cmd_start, has tx_first low.
- R6: A NAK reported in the cycle a transmit byte is accepted ends the transfer at once: dma_en bit 0 clears and the address and length keep the values they had after that byte's fetch.
- R7: A memory error on a transmit read ends the transfer without offering that byte: fault rises, dma_en bit 0 clears, and address and length stay at the failing byte.
- R8: In receive mode each byte accepted from the sequencer is written to memory at the current address, with the same per-byte step of address and length; when the length reaches zero the receive enable (dma_en bit 1) clears.
- R9: A memory error on a receive write stops the engine with address and length at the failing byte, fault high and dma_en bit 1 still set, and no further request; the next accepted command replaces the enables and clears fault.
- R10: With HAS_DMA = 0, register writes have no effect, every register read returns all ones, and commands with a direction bit set are dropped so that no enable bit ever rises.
- R11: A command with both direction bits set runs transmit only; register writes and commands that arrive while a transfer is running are ignored.
- R12: At most one memory request is outstanding, and its address and direction stay unchanged from the cycle it is raised until the cycle of its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 address, 1 length (reads and writes) |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Value of the selected register |
| cmd_wr | input | 1 | Command strobe |
| cmd_start | input | 1 | Command follows a START; first transmit byte is the address byte |
| cmd_tx_dma | input | 1 | Command enables the transmit direction |
| cmd_rx_dma | input | 1 | Command enables the receive direction |
| dma_en | output | 2 | Enable bits: bit 0 transmit, bit 1 receive |
| len_bad | output | 1 | Last length written was zero |
| fault | output | 1 | Last transfer ended on a memory error |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Memory response strobe |
| mem_err | input | 1 | Response carries an error |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_first | output | 1 | Offered byte is the address byte |
| tx_ready | input | 1 | Sequencer takes the transmit byte |
| tx_nak | input | 1 | Byte taken this cycle was not acknowledged |
| rx_ready | output | 1 | Engine can take a received byte |
| rx_valid | input | 1 | Sequencer offers a received byte |
| rx_data | input | 8 | Received byte |

## Verification
Two pairs of events can land in one cycle. The length running out and a NAK can coincide on a transmit byte, and either one alone must end the transfer. A register or command write can also arrive while a memory response is being taken; it must be dropped even though the same response steps the address. The bench provokes the first by placing a NAK on an interior byte and by ending transfers on the count, and the second by writing the address register and a receive command right after a transmit command is accepted. It then reads back the address and length at the ports and compares them with the values the stepping rule predicts.

// File: rtl/i2c_dma_pkg.sv
package i2c_dma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_DISP  = 3'd1,
      ST_FETCH = 3'd2,
      ST_SEND  = 3'd3,
      ST_PULL  = 3'd4,
      ST_STORE = 3'd5,
      ST_HALT  = 3'd6
   } eng_state_t;

   localparam int unsigned EN_TX_BIT = 0;
   localparam int unsigned EN_RX_BIT = 1;

endpackage

// File: rtl/i2c_dma_regs.sv
module i2c_dma_regs #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LEN_W      = 12,
   parameter int unsigned ALIGN_BITS = 2,
   parameter bit          HAS_DMA    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [31:0]       wr_data,
   input  logic              rd_sel,
   output logic [31:0]       rd_data,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic [LEN_W-1:0]  len,
   output logic              len_bad
);

   if (HAS_DMA) begin : g_regs
      logic [ADDR_W-1:0] addr_q;
      logic [LEN_W-1:0]  len_q;
      logic              bad_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            addr_q <= '0;
            len_q  <= '0;
            bad_q  <= 1'b0;
         end else if (wr_en && !wr_sel) begin
            addr_q <= {wr_data[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
         end else if (wr_en && wr_sel) begin
            len_q <= wr_data[LEN_W-1:0];
            bad_q <= (wr_data[LEN_W-1:0] == '0);
         end else if (step) begin
            addr_q <= addr_q + ADDR_W'(1);
            len_q  <= len_q - LEN_W'(1);
         end
      end

      assign addr    = addr_q;
      assign len     = len_q;
      assign len_bad = bad_q;
      assign rd_data = rd_sel ? 32'(len_q) : 32'(addr_q);

      // R1
      addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !wr_sel) |=> (addr[ALIGN_BITS-1:0] == '0));

      // R4
      step_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         step |-> (len != '0));

      // R4
      step_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (step && !wr_en) |=> (len == LEN_W'($past(len) - LEN_W'(1))));
   end else begin : g_absent
      assign addr    = '0;
      assign len     = '0;
      assign len_bad = 1'b0;
      assign rd_data = '1;
   end

endmodule

// File: rtl/i2c_dma_cmd.sv
module i2c_dma_cmd #(
   parameter bit HAS_DMA = 1'b1
) (
   input  logic cmd_wr,
   input  logic cmd_start,
   input  logic cmd_tx,
   input  logic cmd_rx,
   input  logic idle,
   output logic accept,
   output logic go_tx,
   output logic go_rx,
   output logic go_first
);

   localparam logic ENGINE_ON = HAS_DMA;

   logic wants_dma;

   always_comb begin
      wants_dma = cmd_tx || cmd_rx;
      accept    = cmd_wr && idle && (ENGINE_ON || !wants_dma);
      go_tx     = ENGINE_ON && cmd_tx;
      go_rx     = ENGINE_ON && cmd_rx && !cmd_tx;
      go_first  = go_tx && cmd_start;
   end

endmodule

// File: rtl/i2c_dma_engine.sv
module i2c_dma_engine
   import i2c_dma_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              go_tx,
   input  logic              go_rx,
   input  logic              go_first,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   output logic              step,
   output logic              idle,
   output logic              tx_en,
   output logic              rx_en,
   output logic              fault,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic [7:0]        mem_rdata,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_first,
   input  logic              tx_ready,
   input  logic              tx_nak,
   output logic              rx_ready,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data
);

   eng_state_t state_q;
   logic       tx_en_q, rx_en_q, first_q, fault_q;
   logic [7:0] data_q;
   logic       len_last;

   assign len_last = (len == LEN_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tx_en_q <= 1'b0;
         rx_en_q <= 1'b0;
         first_q <= 1'b0;
         fault_q <= 1'b0;
         data_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE, ST_HALT: begin
               if (accept) begin
                  tx_en_q <= go_tx;
                  rx_en_q <= go_rx;
                  first_q <= go_first;
                  fault_q <= 1'b0;
                  state_q <= (go_tx || go_rx) ? ST_DISP : ST_IDLE;
               end
            end
            ST_DISP: begin
               if (len == '0) begin
                  tx_en_q <= 1'b0;
                  rx_en_q <= 1'b0;
                  first_q <= 1'b0;
                  state_q <= ST_IDLE;
               end else if (tx_en_q) begin
                  state_q <= ST_FETCH;
               end else begin
                  state_q <= ST_PULL;
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  if (mem_err) begin
                     fault_q <= 1'b1;
                     tx_en_q <= 1'b0;
                     first_q <= 1'b0;
                     state_q <= ST_IDLE;
                  end else begin
                     data_q  <= mem_rdata;
                     state_q <= ST_SEND;
                  end
               end
            end
            ST_SEND: begin
               if (tx_ready) begin
                  first_q <= 1'b0;
                  if (tx_nak || (len == '0)) begin
                     tx_en_q <= 1'b0;
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_FETCH;
                  end
               end
            end
            ST_PULL: begin
               if (rx_valid) begin
                  data_q  <= rx_data;
                  state_q <= ST_STORE;
               end
            end
            ST_STORE: begin
               if (mem_ack) begin
                  if (mem_err) begin
                     fault_q <= 1'b1;
                     state_q <= ST_HALT;
                  end else if (len_last) begin
                     rx_en_q <= 1'b0;
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_PULL;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      idle      = (state_q == ST_IDLE) || (state_q == ST_HALT);
      mem_req   = (state_q == ST_FETCH) || (state_q == ST_STORE);
      mem_we    = (state_q == ST_STORE);
      mem_addr  = addr;
      mem_wdata = data_q;
      step      = mem_req && mem_ack && !mem_err;
      tx_valid  = (state_q == ST_SEND);
      tx_data   = data_q;
      tx_first  = (state_q == ST_SEND) && first_q;
      rx_ready  = (state_q == ST_PULL);
      tx_en     = tx_en_q;
      rx_en     = rx_en_q;
      fault     = fault_q;
   end

   // R12
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R11
   dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_en && rx_en));

   // R6
   nak_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_nak) |=> (!tx_en && !tx_valid));

   // R7
   tx_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack && mem_err) |=> (!tx_valid && !tx_en && fault));

   // R9
   rx_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack && mem_err) |=> (rx_en && fault && !mem_req && !rx_ready));

   // R3
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((tx_en || rx_en) && idle == 1'b0 && !mem_req && !tx_valid && !rx_ready && len == '0
        && !$past(mem_ack)) |=> (!tx_en && !rx_en && !mem_req));

endmodule

// File: rtl/i2c_dma_mover.sv
module i2c_dma_mover
   import i2c_dma_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LEN_W      = 12,
   parameter int unsigned ALIGN_BITS = 2,
   parameter bit          HAS_DMA    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              cmd_wr,
   input  logic              cmd_start,
   input  logic              cmd_tx_dma,
   input  logic              cmd_rx_dma,
   output logic [1:0]        dma_en,
   output logic              len_bad,
   output logic              fault,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic [7:0]        mem_rdata,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_first,
   input  logic              tx_ready,
   input  logic              tx_nak,
   output logic              rx_ready,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data
);

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
      $error("i2c_dma_mover: ADDR_W must lie in 8..32");
   end
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len_w
      $error("i2c_dma_mover: LEN_W must lie in 1..16");
   end
   if (ALIGN_BITS < 1 || ALIGN_BITS >= ADDR_W) begin : g_bad_align
      $error("i2c_dma_mover: ALIGN_BITS must lie in 1..ADDR_W-1");
   end

   logic              idle, step, accept;
   logic              go_tx, go_rx, go_first;
   logic              tx_en, rx_en;
   logic [ADDR_W-1:0] cur_addr;
   logic [LEN_W-1:0]  cur_len;

   i2c_dma_regs #(
      .ADDR_W    (ADDR_W),
      .LEN_W     (LEN_W),
      .ALIGN_BITS(ALIGN_BITS),
      .HAS_DMA   (HAS_DMA)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_wr && idle),
      .wr_sel (reg_sel),
      .wr_data(reg_wdata),
      .rd_sel (reg_sel),
      .rd_data(reg_rdata),
      .step   (step),
      .addr   (cur_addr),
      .len    (cur_len),
      .len_bad(len_bad)
   );

   i2c_dma_cmd #(
      .HAS_DMA(HAS_DMA)
   ) u_cmd (
      .cmd_wr   (cmd_wr),
      .cmd_start(cmd_start),
      .cmd_tx   (cmd_tx_dma),
      .cmd_rx   (cmd_rx_dma),
      .idle     (idle),
      .accept   (accept),
      .go_tx    (go_tx),
      .go_rx    (go_rx),
      .go_first (go_first)
   );

   i2c_dma_engine #(
      .ADDR_W(ADDR_W),
      .LEN_W (LEN_W)
   ) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .go_tx    (go_tx),
      .go_rx    (go_rx),
      .go_first (go_first),
      .addr     (cur_addr),
      .len      (cur_len),
      .step     (step),
      .idle     (idle),
      .tx_en    (tx_en),
      .rx_en    (rx_en),
      .fault    (fault),
      .mem_req  (mem_req),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_ack  (mem_ack),
      .mem_err  (mem_err),
      .mem_rdata(mem_rdata),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .tx_first (tx_first),
      .tx_ready (tx_ready),
      .tx_nak   (tx_nak),
      .rx_ready (rx_ready),
      .rx_valid (rx_valid),
      .rx_data  (rx_data)
   );

   always_comb begin
      dma_en            = '0;
      dma_en[EN_TX_BIT] = tx_en;
      dma_en[EN_RX_BIT] = rx_en;
   end

   // R10
   idle_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !HAS_DMA |-> (dma_en == 2'b00 && !mem_req));

endmodule

// File: tb/tb_i2c_dma_mover.sv
module tb_i2c_dma_mover;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic        reg_wr, reg_sel, cmd_wr, cmd_start, cmd_tx, cmd_rx;
   logic [31:0] reg_wdata, reg_rdata;
   logic [1:0]  dma_en;
   logic        len_bad, fault;
   logic        mem_req, mem_we, mem_ack, mem_err;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        tx_valid, tx_first, tx_ready, tx_nak;
   logic [7:0]  tx_data;
   logic        rx_ready, rx_valid;
   logic [7:0]  rx_data;

   logic        n_reg_wr, n_cmd_wr;
   logic [31:0] n_reg_rdata, n_mem_addr;
   logic [1:0]  n_dma_en;
   logic        n_len_bad, n_fault, n_mem_req, n_mem_we, n_tx_valid, n_tx_first, n_rx_ready;
   logic [7:0]  n_mem_wdata, n_tx_data;

   i2c_dma_mover dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_wr(cmd_wr),
      .cmd_start(cmd_start), .cmd_tx_dma(cmd_tx), .cmd_rx_dma(cmd_rx),
      .dma_en(dma_en), .len_bad(len_bad), .fault(fault), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_first(tx_first),
      .tx_ready(tx_ready), .tx_nak(tx_nak), .rx_ready(rx_ready),
      .rx_valid(rx_valid), .rx_data(rx_data)
   );

   i2c_dma_mover #(.HAS_DMA(1'b0)) dut_nodma (
      .clk(clk), .rst_n(rst_n), .reg_wr(n_reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(n_reg_rdata), .cmd_wr(n_cmd_wr),
      .cmd_start(cmd_start), .cmd_tx_dma(cmd_tx), .cmd_rx_dma(cmd_rx),
      .dma_en(n_dma_en), .len_bad(n_len_bad), .fault(n_fault), .mem_req(n_mem_req),
      .mem_we(n_mem_we), .mem_addr(n_mem_addr), .mem_wdata(n_mem_wdata),
      .mem_ack(1'b0), .mem_err(1'b0), .mem_rdata(8'h00),
      .tx_valid(n_tx_valid), .tx_data(n_tx_data), .tx_first(n_tx_first),
      .tx_ready(1'b0), .tx_nak(1'b0), .rx_ready(n_rx_ready),
      .rx_valid(1'b0), .rx_data(8'h00)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0]  mem [0:255];
   logic [8:0]  exp_tx [$];
   logic [39:0] exp_wr [$];
   logic [7:0]  rx_src [$];
   logic [31:0] err_addr = 32'hFFFF_FFFF;
   logic [31:0] held_addr;
   int wait_cnt = 0;
   int req_cycles = 0;
   int nak_idx = -1;
   int tx_cnt = 0;
   int n_req_seen = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory responder and write monitor
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0; mem_err = 1'b0; wait_cnt = 0;
      end else if (mem_ack) begin
         mem_ack = 1'b0; mem_err = 1'b0; wait_cnt = 0;
      end else if (mem_req) begin
         req_cycles++;
         if (wait_cnt == 0) held_addr = mem_addr;
         wait_cnt++;
         if (wait_cnt >= 2) begin
            chk("R12 request held", mem_addr, held_addr);
            mem_ack = 1'b1;
            mem_err = (mem_addr == err_addr);
            if (!mem_we) mem_rdata = mem[mem_addr[7:0]];
            else if (!mem_err) begin
               if (exp_wr.size() == 0) chk("R8 unexpected write", 32'(mem_addr), 32'hDEAD_BEEF);
               else begin
                  logic [39:0] e;
                  e = exp_wr.pop_front();
                  chk("R8 write addr", mem_addr, e[39:8]);
                  chk("R8 write data", 32'(mem_wdata), 32'(e[7:0]));
               end
               mem[mem_addr[7:0]] = mem_wdata;
            end
         end
      end
      if (n_mem_req) n_req_seen++;
   end

   // sequencer model and transmit monitor
   always @(negedge clk) begin
      if (!rst_n) begin
         tx_ready = 1'b0; tx_nak = 1'b0; rx_valid = 1'b0; rx_data = 8'h00;
      end else begin
         if (tx_ready) begin
            tx_ready = 1'b0; tx_nak = 1'b0;
         end else if (tx_valid) begin
            if (exp_tx.size() == 0) chk("R4 unexpected tx byte", 32'(tx_data), 32'hDEAD_BEEF);
            else begin
               logic [8:0] e;
               e = exp_tx.pop_front();
               chk("R4 tx byte", 32'(tx_data), 32'(e[7:0]));
               chk("R5 address flag", 32'(tx_first), 32'(e[8]));
            end
            tx_ready = 1'b1;
            tx_nak   = (tx_cnt == nak_idx);
            tx_cnt++;
         end
         if (rx_valid) rx_valid = 1'b0;
         else if (rx_ready) begin
            rx_valid = 1'b1;
            rx_data  = (rx_src.size() != 0) ? rx_src.pop_front() : 8'h00;
         end
      end
   end

   task automatic reg_write(input logic sel, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic sel, output logic [31:0] v);
      @(negedge clk); reg_sel = sel; #1 v = reg_rdata;
   endtask

   task automatic command(input logic s, input logic t, input logic r);
      @(negedge clk); cmd_wr = 1'b1; cmd_start = s; cmd_tx = t; cmd_rx = r;
      @(negedge clk); cmd_wr = 1'b0; cmd_start = 1'b0; cmd_tx = 1'b0; cmd_rx = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (dma_en != 2'b00 && !(dma_en[1] && fault) && n < 2000) begin
         @(negedge clk); n++;
      end
      if (n >= 2000) chk("transfer watchdog", 32'(n), 32'd0);
      repeat (2) @(negedge clk);
   endtask

   task automatic push_tx(input int base, input int count, input logic start);
      for (int i = 0; i < count; i++)
         exp_tx.push_back({start && (i == 0), mem[8'(base + i)]});
   endtask

   task automatic check_regs(input string req, input logic [31:0] a, input logic [31:0] l);
      logic [31:0] v;
      reg_read(1'b0, v); chk({req, " address"}, v, a);
      reg_read(1'b1, v); chk({req, " length"}, v, l);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int r0;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
      rst_n = 1'b0; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
      cmd_wr = 0; cmd_start = 0; cmd_tx = 0; cmd_rx = 0;
      n_reg_wr = 0; n_cmd_wr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state (R1, R2)
      check_regs("R1 R2 reset", 32'h0, 32'h0);
      chk("R4 reset enables", 32'(dma_en), 32'h0);
      chk("R7 reset fault", 32'(fault), 32'h0);
      chk("R3 reset len_bad", 32'(len_bad), 32'h0);

      // R1 alignment, R2 truncation
      reg_write(1'b0, 32'h1234_5673);
      reg_read(1'b0, v); chk("R1 aligned address", v, 32'h1234_5670);
      reg_write(1'b1, 32'h000A_BC05);
      reg_read(1'b1, v); chk("R2 twelve-bit length", v, 32'h0000_0C05);

      // R3 zero length
      reg_write(1'b1, 32'h0000_5000);
      chk("R3 len_bad raised", 32'(len_bad), 32'h1);
      r0 = req_cycles;
      command(1'b1, 1'b1, 1'b0);
      wait_done();
      chk("R3 no memory request", 32'(req_cycles), 32'(r0));
      chk("R3 enable dropped", 32'(dma_en), 32'h0);
      reg_write(1'b1, 32'h5);
      chk("R3 len_bad cleared", 32'(len_bad), 32'h0);

      // R4 R5 transmit with START
      reg_write(1'b0, 32'h20); reg_write(1'b1, 32'h4);
      push_tx(32'h20, 4, 1'b1); tx_cnt = 0; nak_idx = -1;
      command(1'b1, 1'b1, 1'b0);
      wait_done();
      check_regs("R4 after transmit", 32'h24, 32'h0);
      chk("R4 enable cleared", 32'(dma_en), 32'h0);
      chk("R4 queue drained", 32'(exp_tx.size()), 32'h0);

      // R6 NAK on third byte, no START
      reg_write(1'b0, 32'h40); reg_write(1'b1, 32'h5);
      push_tx(32'h40, 3, 1'b0); tx_cnt = 0; nak_idx = 2;
      command(1'b0, 1'b1, 1'b0);
      wait_done();
      nak_idx = -1;
      check_regs("R6 after NAK", 32'h43, 32'h2);
      chk("R6 enable cleared", 32'(dma_en), 32'h0);
      chk("R6 queue drained", 32'(exp_tx.size()), 32'h0);

      // R7 read error on third byte
      reg_write(1'b0, 32'h60); reg_write(1'b1, 32'h4);
      push_tx(32'h60, 2, 1'b0); tx_cnt = 0; err_addr = 32'h62;
      command(1'b0, 1'b1, 1'b0);
      wait_done();
      err_addr = 32'hFFFF_FFFF;
      chk("R7 fault", 32'(fault), 32'h1);
      chk("R7 enable cleared", 32'(dma_en), 32'h0);
      check_regs("R7 after read error", 32'h62, 32'h2);
      chk("R7 failed byte not sent", 32'(exp_tx.size()), 32'h0);

      // R8 receive
      reg_write(1'b0, 32'h80); reg_write(1'b1, 32'h3);
      rx_src = '{8'hA1, 8'hB2, 8'hC3};
      exp_wr.push_back({32'h80, 8'hA1});
      exp_wr.push_back({32'h81, 8'hB2});
      exp_wr.push_back({32'h82, 8'hC3});
      command(1'b0, 1'b0, 1'b1);
      wait_done();
      check_regs("R8 after receive", 32'h83, 32'h0);
      chk("R8 enable cleared", 32'(dma_en), 32'h0);
      chk("R8 writes drained", 32'(exp_wr.size()), 32'h0);
      chk("R8 fault clear", 32'(fault), 32'h0);

      // R9 write error on second byte
      reg_write(1'b0, 32'hA0); reg_write(1'b1, 32'h4);
      rx_src = '{8'h11, 8'h22, 8'h33, 8'h44};
      exp_wr.push_back({32'hA0, 8'h11});
      err_addr = 32'hA1;
      command(1'b0, 1'b0, 1'b1);
      wait_done();
      err_addr = 32'hFFFF_FFFF;
      chk("R9 receive enable kept", 32'(dma_en), 32'h2);
      chk("R9 fault", 32'(fault), 32'h1);
      r0 = req_cycles;
      repeat (4) @(negedge clk);
      chk("R9 no further request", 32'(req_cycles), 32'(r0));
      check_regs("R9 after write error", 32'hA1, 32'h3);
      rx_src.delete();
      command(1'b0, 1'b0, 1'b0);
      chk("R9 enables replaced", 32'(dma_en), 32'h0);
      chk("R9 fault cleared", 32'(fault), 32'h0);

      // R11 both bits, writes ignored while running
      reg_write(1'b0, 32'hC0); reg_write(1'b1, 32'h2);
      push_tx(32'hC0, 2, 1'b0); tx_cnt = 0;
      command(1'b0, 1'b1, 1'b1);
      chk("R11 transmit only", 32'(dma_en), 32'h1);
      reg_write(1'b0, 32'h1000);
      command(1'b0, 1'b0, 1'b1);
      wait_done();
      check_regs("R11 busy writes ignored", 32'hC2, 32'h0);
      chk("R11 queue drained", 32'(exp_tx.size()), 32'h0);

      // R10 engine absent
      @(negedge clk); n_reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h44;
      @(negedge clk); n_reg_wr = 1'b0;
      #1 chk("R10 address reads ones", n_reg_rdata, 32'hFFFF_FFFF);
      @(negedge clk); reg_sel = 1'b1;
      #1 chk("R10 length reads ones", n_reg_rdata, 32'hFFFF_FFFF);
      @(negedge clk); n_cmd_wr = 1'b1; cmd_tx = 1'b1; cmd_start = 1'b1;
      @(negedge clk); n_cmd_wr = 1'b0; cmd_tx = 1'b0; cmd_start = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 enables stay low", 32'(n_dma_en), 32'h0);
      chk("R10 no memory traffic", 32'(n_req_seen), 32'h0);
      chk("R10 no transmit byte", 32'(n_tx_valid), 32'h0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule